// File: doc/BRIEF.md
# Split-Access 64-bit Time Base

A free-running 64-bit tick counter that a 32-bit register bus reads and writes as two halves. The counter advances by one on every clock edge where the external tick-enable input is high. This keeps the tick rate independent of the bus clock, for example a 125 MHz time base beside a core clock eight times faster. Reads return the live upper or lower half. No snapshot latch ties the two halves together, so a carry out of the lower half can land between two reads. Software gets a consistent 64-bit value by reading the upper half, then the lower half, then the upper half again, and retrying while the two upper values differ.

Loading the counter goes through two write-only registers at addresses separate from the read addresses. Software writes zero to the lower half, then the new upper half, then the new lower half. With the lower half just cleared, no carry can reach the upper half while the update is in progress. A write replaces the addressed half on the next edge, and it takes precedence over a tick in the same cycle. The counter wraps from all ones to zero with no flag.

Top module: `split_timebase`

## Requirements
- R1: After reset the counter is zero, `bus_rvalid` is 0 and `bus_rdata` is 0.
- R2: On every clock edge where `tick_en` is 1 and no write is accepted, the counter increases by one. With `tick_en` at 0 and no write, it holds its value.
- R3: A read (`bus_valid`=1, `bus_write`=0) at address 0 returns the lower 32 bits, and at address 1 the upper 32 bits. The data appears on `bus_rdata` with `bus_rvalid`=1 one cycle later and holds the counter value from before that edge's update. `bus_rvalid` is 0 in every cycle after a cycle with no read.
- R4: Reading one half neither freezes nor latches the other. A carry out of the lower half between an upper read and a lower read is visible, so an upper-lower-upper sequence returns two different upper values.
- R5: A write (`bus_valid`=1, `bus_write`=1) at address 2 loads the lower half, and at address 3 the upper half, from `bus_wdata` on the next edge. The other half keeps its value, and a tick in the same cycle is discarded.
- R6: A write to read address 0 or 1 leaves the counter unchanged.
- R7: A read of write-only address 2 or 3 returns 0 with `bus_rvalid`=1.
- R8: From all ones, one tick takes the counter to zero, with no other indication.
- R9: With ticks running, the sequence "write 0 to the lower half, write U to the upper half, write L to the lower half" leaves exactly {U, L}, even when the old lower half was close to overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Time-base tick qualifier, one count per high cycle |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 read lower, 1 read upper, 2 write lower, 3 write upper |
| bus_wdata | input | 32 | Write data for the addressed half |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |

## Verification
The counter is exercised with idle ticking, with ticks suppressed, and with ticks that coincide with reads and with writes. These show whether a read samples the value before the edge and whether a write overrides the increment. A lower half loaded near all ones, with ticks running between reads, separates live independent halves from any hidden snapshot. The same near-overflow load is used to show that the zero-first write order yields the exact target value. Writes to read addresses and reads of write addresses confirm that the two address sets stay apart. An all-ones load followed by one tick confirms the silent wrap.

// File: rtl/stb_pkg.sv
package stb_pkg;

    // Bus address map: reads and writes use disjoint locations
    typedef enum logic [1:0] {
        ADR_RD_LO = 2'd0,
        ADR_RD_HI = 2'd1,
        ADR_WR_LO = 2'd2,
        ADR_WR_HI = 2'd3
    } stb_addr_e;

    // Decoded access for one bus cycle, at most one bit set
    typedef struct packed {
        logic wr_lo;
        logic wr_hi;
        logic rd_lo;
        logic rd_hi;
        logic rd_void;
    } stb_cmd_t;

endpackage

// File: rtl/stb_decode.sv
module stb_decode
    import stb_pkg::*;
(
    input  logic       bus_valid,
    input  logic       bus_write,
    input  logic [1:0] bus_addr,
    output stb_cmd_t   cmd
);

    stb_addr_e adr;

    always_comb begin
        adr = stb_addr_e'(bus_addr);
        cmd = '0;
        if (bus_valid) begin
            if (bus_write) begin
                // writes to read-only locations fall through and do nothing
                cmd.wr_lo = (adr == ADR_WR_LO);
                cmd.wr_hi = (adr == ADR_WR_HI);
            end else begin
                cmd.rd_lo   = (adr == ADR_RD_LO);
                cmd.rd_hi   = (adr == ADR_RD_HI);
                cmd.rd_void = (adr == ADR_WR_LO) || (adr == ADR_WR_HI);
            end
        end
    end

endmodule

// File: rtl/stb_counter.sv
module stb_counter #(
    parameter int CNT_W  = 64,
    localparam int HALF_W = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt
);

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } cnt_t;

    cnt_t              cnt_d, cnt_q;
    logic [HALF_W:0]   lo_sum;
    logic              lo_carry;

    always_comb begin
        cnt_d    = cnt_q;
        lo_sum   = {1'b0, cnt_q.lo} + (HALF_W + 1)'(1);
        lo_carry = lo_sum[HALF_W];
        if (wr_lo || wr_hi) begin
            // a load wins over a tick; the other half is left as is
            if (wr_lo) cnt_d.lo = wdata;
            if (wr_hi) cnt_d.hi = wdata;
        end else if (tick_en) begin
            cnt_d.lo = lo_sum[HALF_W-1:0];
            cnt_d.hi = cnt_q.hi + HALF_W'(lo_carry);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/stb_readport.sv
module stb_readport
    import stb_pkg::*;
#(
    parameter int CNT_W  = 64,
    localparam int HALF_W = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stb_cmd_t          cmd,
    input  logic [CNT_W-1:0]  cnt,
    output logic [HALF_W-1:0] rdata,
    output logic              rvalid
);

    typedef struct packed {
        logic              vld;
        logic [HALF_W-1:0] dat;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d     = rsp_q;
        rsp_d.vld = cmd.rd_lo || cmd.rd_hi || cmd.rd_void;
        // live halves, no latch between them
        if (cmd.rd_lo)        rsp_d.dat = cnt[HALF_W-1:0];
        else if (cmd.rd_hi)   rsp_d.dat = cnt[CNT_W-1:HALF_W];
        else if (cmd.rd_void) rsp_d.dat = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rdata  = rsp_q.dat;
    assign rvalid = rsp_q.vld;

endmodule

// File: rtl/split_timebase.sv
module split_timebase
    import stb_pkg::*;
#(
    parameter int CNT_W  = 64,
    localparam int BUS_W = CNT_W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             bus_rvalid
);

    stb_cmd_t         cmd;
    logic [CNT_W-1:0] cnt_q;

    stb_decode u_decode (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .cmd       (cmd)
    );

    stb_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .wr_lo   (cmd.wr_lo),
        .wr_hi   (cmd.wr_hi),
        .wdata   (bus_wdata),
        .cnt     (cnt_q)
    );

    stb_readport #(.CNT_W(CNT_W)) u_readport (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd    (cmd),
        .cnt    (cnt_q),
        .rdata  (bus_rdata),
        .rvalid (bus_rvalid)
    );

endmodule

// File: rtl/split_timebase_chk.sv
module split_timebase_chk #(
    parameter int CNT_W  = 64,
    localparam int BUS_W = CNT_W / 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             bus_valid,
    input logic             bus_write,
    input logic [1:0]       bus_addr,
    input logic [BUS_W-1:0] bus_wdata,
    input logic [BUS_W-1:0] bus_rdata,
    input logic             bus_rvalid,
    input logic [CNT_W-1:0] cnt_q
);

    logic any_load, rd_cyc;
    assign any_load = bus_valid && bus_write && bus_addr[1];
    assign rd_cyc   = bus_valid && !bus_write;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $rose(rst_n) |-> (cnt_q == '0 && !bus_rvalid));                        // R1

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !any_load) |=> cnt_q == $past(cnt_q) + CNT_W'(1));          // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !(bus_valid && bus_write)) |=> $stable(cnt_q));            // R2

    AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cyc |=> bus_rvalid);                                                 // R3

    AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_cyc |=> !bus_rvalid);                                               // R3

    AST_RD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cyc && bus_addr == 2'd1) |=> bus_rdata == $past(cnt_q[CNT_W-1:BUS_W])); // R4

    AST_LOAD_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == 2'd2) |=>
        (cnt_q[BUS_W-1:0] == $past(bus_wdata) &&
         cnt_q[CNT_W-1:BUS_W] == $past(cnt_q[CNT_W-1:BUS_W])));                 // R5

    AST_LOAD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == 2'd3) |=>
        (cnt_q[CNT_W-1:BUS_W] == $past(bus_wdata) &&
         cnt_q[BUS_W-1:0] == $past(cnt_q[BUS_W-1:0])));                         // R5

    AST_RO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && !bus_addr[1]) |=>
        (tick_en ? 1'b1 : 1'b1) && (cnt_q == $past(cnt_q) ||
         cnt_q == $past(cnt_q) + CNT_W'(1)));                                   // R6

    AST_VOID_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cyc && bus_addr[1]) |=> bus_rdata == '0);                           // R7

    AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !any_load && cnt_q == '1) |=> cnt_q == '0);                 // R8

endmodule

bind split_timebase split_timebase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .cnt_q      (cnt_q)
);

// File: tb/split_timebase_tb_top.sv
module split_timebase_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_en;
    logic        bus_valid;
    logic        bus_write;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;

    always #10 clk = ~clk;

    split_timebase dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic w, input logic [1:0] a,
                         input logic [31:0] d, input logic t);
        @(negedge clk);
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d; tick_en = t;
    endtask

    task automatic idle(input logic t);
        drive(1'b0, 1'b0, 2'd0, 32'h0, t);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic t);
        drive(1'b1, 1'b1, a, d, t);
    endtask

    task automatic rd(input logic [1:0] a, input logic t, input logic [31:0] exp, input string tag);
        drive(1'b1, 1'b0, a, 32'h0, t);
        sb_q.push_back('{exp, tag});
    endtask

    // Monitor: pops one expected item per returned read
    always @(negedge clk) begin
        if (rst_n === 1'b1 && bus_rvalid === 1'b1) begin
            if (sb_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R3: actual=unexpected rvalid expected=no response");
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(bus_rdata, it.exp, it.tag);
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all): actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; tick_en = 1'b1; bus_valid = 1'b0; bus_write = 1'b0;
        bus_addr = 2'd0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; tick_en = 1'b0;
        @(negedge clk);
        check({31'b0, bus_rvalid}, 32'h0, "R1 rvalid");
        check(bus_rdata, 32'h0, "R1 rdata");
        rd(2'd0, 1'b0, 32'h0, "R1 lower");
        rd(2'd1, 1'b0, 32'h0, "R1 upper");

        // R2: five ticks, then hold
        repeat (5) idle(1'b1);
        rd(2'd0, 1'b0, 32'd5, "R2 count");
        repeat (3) idle(1'b0);
        rd(2'd0, 1'b0, 32'd5, "R2 hold");

        // R3: read in a tick cycle sees pre-edge value
        rd(2'd0, 1'b1, 32'd5, "R3 pre-edge");
        rd(2'd0, 1'b0, 32'd6, "R3 after");

        // R5: loads beat a simultaneous tick
        wr(2'd2, 32'h1234_5678, 1'b1);
        rd(2'd0, 1'b0, 32'h1234_5678, "R5 lower");
        rd(2'd1, 1'b0, 32'h0, "R5 upper kept");
        wr(2'd3, 32'hABCD_0001, 1'b1);
        rd(2'd1, 1'b0, 32'hABCD_0001, "R5 upper");
        rd(2'd0, 1'b0, 32'h1234_5678, "R5 lower kept");

        // R6: writes to read addresses ignored
        wr(2'd0, 32'hDEAD_BEEF, 1'b0);
        wr(2'd1, 32'hDEAD_BEEF, 1'b0);
        rd(2'd0, 1'b0, 32'h1234_5678, "R6 lower");
        rd(2'd1, 1'b0, 32'hABCD_0001, "R6 upper");

        // R7: write-only addresses read as zero
        rd(2'd2, 1'b0, 32'h0, "R7 addr2");
        rd(2'd3, 1'b0, 32'h0, "R7 addr3");

        // R4: carry lands between upper and lower reads
        wr(2'd2, 32'hFFFF_FFFE, 1'b0);
        wr(2'd3, 32'd5, 1'b0);
        rd(2'd1, 1'b0, 32'd5, "R4 first upper");
        idle(1'b1);
        idle(1'b1);
        rd(2'd0, 1'b0, 32'h0, "R4 lower");
        rd(2'd1, 1'b0, 32'd6, "R4 second upper");

        // R8: silent wrap
        wr(2'd2, 32'hFFFF_FFFF, 1'b0);
        wr(2'd3, 32'hFFFF_FFFF, 1'b0);
        rd(2'd1, 1'b0, 32'hFFFF_FFFF, "R8 upper ones");
        rd(2'd0, 1'b1, 32'hFFFF_FFFF, "R8 lower ones");
        rd(2'd1, 1'b0, 32'h0, "R8 upper wrapped");
        rd(2'd0, 1'b0, 32'h0, "R8 lower wrapped");

        // R9: safe load order with ticks running, old lower near overflow
        wr(2'd2, 32'hFFFF_FFFD, 1'b0);
        wr(2'd3, 32'd7, 1'b0);
        wr(2'd2, 32'h0, 1'b1);
        idle(1'b1);
        idle(1'b1);
        wr(2'd3, 32'h20, 1'b1);
        wr(2'd2, 32'h100, 1'b1);
        rd(2'd1, 1'b0, 32'h20, "R9 upper");
        rd(2'd0, 1'b0, 32'h100, "R9 lower");

        repeat (3) idle(1'b0);
        check(32'(sb_q.size()), 32'h0, "R3 outstanding");
        done = 1'b1;
        summary();
        $finish;
    end

endmodule